// File: doc/BRIEF.md
# Condition-Qualified Interrupt Controller

This block drives one active-low interrupt line from a small set of event sources. Each source keeps a sticky pending flag that its event sets. An enable register masks which pending flags may pull the line low. A pending flag is released only when two things have both happened: the host has read the status register that belongs to that source, and the condition that raised the event has really gone away. The status read and the release of the condition may come in either order.

Two sources are modelled in full. Source 0 raises a flag when a received frame has been parsed and its destination-address lookup result is waiting. It is released once the result buffer reports that every result word has been read. Source 1 raises a flag when the address table's active-low full flag goes from not-full to full. It is released once the table is no longer full, for example after a purge. A status word for the table reports the raw flag with full shown as bit 0 equal to 0. The remaining sources, 2 and up, are general-purpose slots. Each has its own event strobe and its own release level, and each works the same way.

The host-side register decode lies outside this block. It gives the block an enable write strobe with data, and a one-cycle acknowledge pulse per source whenever the matching status register is read.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset `irq_no` is 1, `pend_o` is all zero, the enable register is all zero, and `tbl_stat_o` is `{1'b0, full_n_i}`.
- R2: A one-cycle high on `lkup_done_i` sets `pend_o[0]` at that clock edge.
- R3: A high-to-low change of `full_n_i` between two clock edges sets `pend_o[1]`. While `full_n_i` stays low, `pend_o[1]` stays set, even after an acknowledge on `ack_i[1]`.
- R4: `tbl_stat_o[0]` equals `full_n_i`, so a full table reads as 0. `tbl_stat_o[1]` equals `pend_o[1]`.
- R5: `irq_no` is 0 exactly when some bit i has both `pend_o[i]` and enable bit i set. Enable bit i belongs to source i, and it is loaded from `en_wdata_i` at an edge where `en_we_i` is 1.
- R6: A pending flag is set whether or not its enable bit is set. Setting the enable bit later drives `irq_no` low.
- R7: An acknowledge while the release level is 0 does not clear the flag. The acknowledge is remembered, and the flag clears at the first edge where the release level is 1 (`rslt_empty_i` for source 0, `full_n_i` for source 1, `aux_rel_i` for the other sources).
- R8: While a flag is pending and no acknowledge has been seen, a release level of 1 does not clear it.
- R9: If the release level is already 1, the flag clears at the edge that samples its acknowledge.
- R10: When an event arrives in the same cycle that a clear would happen, the flag stays set. Any remembered acknowledge is dropped, so a fresh acknowledge is needed to clear it.
- R11: An acknowledge while the flag is not pending has no effect. A later event then needs its own acknowledge.
- R12: The general-purpose slots follow R5 to R11, using `aux_evt_i[k]` and `aux_rel_i[k]` as source k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NSRC | Enable bits, bit i for source i |
| lkup_done_i | input | 1 | Lookup result ready strobe (source 0) |
| rslt_empty_i | input | 1 | All result words drained (release for source 0) |
| full_n_i | input | 1 | Table full flag, active low (source 1) |
| aux_evt_i | input | NAUX | Event strobes for general-purpose slots |
| aux_rel_i | input | NAUX | Release levels for general-purpose slots |
| ack_i | input | NSRC | Status-read acknowledge pulses, bit i for source i |
| irq_no | output | 1 | Interrupt, active low |
| pend_o | output | NSRC | Pending flags |
| tbl_stat_o | output | 2 | Table status: bit 0 not-full, bit 1 full pending |

## Verification
Three actions can land on one flag in the same cycle: setting it through an event, clearing it through an acknowledge plus release, and recording an acknowledge. The bench provokes each pairing on purpose. One case drives an event in the same cycle as a release while an acknowledge is already remembered. Another acknowledges before the release arrives, another releases before the acknowledge, and another acknowledges while the flag is idle. After each case the bench judges what happened by watching the pending flags and the interrupt line over the following cycles. A queue-free behavioural model also runs alongside a stretch of random stimulus and is compared on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned SRC_LKUP = 0;
  localparam int unsigned SRC_FULL = 1;
  localparam int unsigned SRC_AUX0 = 2;

  // a flag drops when it is pending, an acknowledge is known, and the cause is gone
  function automatic logic slot_clear(input logic pend, input logic ackd,
                                      input logic ack, input logic rel);
    return pend & (ackd | ack) & rel;
  endfunction

  // an event always wins over a clear
  function automatic logic slot_next_pend(input logic pend, input logic set,
                                          input logic clr);
    return set | (pend & ~clr);
  endfunction

  // remembered acknowledge: only while pending, dropped by a new event or a clear
  function automatic logic slot_next_ackd(input logic pend, input logic ackd,
                                          input logic ack, input logic set,
                                          input logic clr);
    return pend & ~set & ~clr & (ackd | ack);
  endfunction
endpackage

// File: rtl/ic_fall_det.sv
module ic_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fell_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fell_o = prev_q & ~lvl_i;
endmodule

// File: rtl/ic_src_slot.sv
module ic_src_slot
  import evt_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic rel_i,
  output logic pend_o,
  output logic ackd_o,
  output logic clr_o
);
  logic pend_q, ackd_q;
  logic pend_d, ackd_d, clr_w;

  always_comb begin
    clr_w  = slot_clear(pend_q, ackd_q, ack_i, rel_i);
    pend_d = slot_next_pend(pend_q, set_i, clr_w);
    ackd_d = slot_next_ackd(pend_q, ackd_q, ack_i, set_i, clr_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ackd_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ackd_q <= ackd_d;
    end
  end

  assign pend_o = pend_q;
  assign ackd_o = ackd_q;
  assign clr_o  = clr_w;
endmodule

// File: rtl/ic_irq_merge.sv
module ic_irq_merge #(
  parameter int unsigned NSRC = 4
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_no
);
  logic [NSRC-1:0] live_w;

  assign live_w = pend_i & en_i;
  assign irq_no = ~(|live_w);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NAUX = 2,
  localparam int unsigned NSRC = SRC_AUX0 + NAUX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_we_i,
  input  logic [NSRC-1:0] en_wdata_i,
  input  logic            lkup_done_i,
  input  logic            rslt_empty_i,
  input  logic            full_n_i,
  input  logic [NAUX-1:0] aux_evt_i,
  input  logic [NAUX-1:0] aux_rel_i,
  input  logic [NSRC-1:0] ack_i,
  output logic            irq_no,
  output logic [NSRC-1:0] pend_o,
  output logic [1:0]      tbl_stat_o
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] set_w, rel_w, clr_w, ackd_w, pend_w;
  logic            full_fell_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  ic_fall_det u_full_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (full_n_i),
    .fell_o (full_fell_w)
  );

  always_comb begin
    set_w = '0;
    rel_w = '0;
    set_w[SRC_LKUP] = lkup_done_i;
    rel_w[SRC_LKUP] = rslt_empty_i;
    set_w[SRC_FULL] = full_fell_w;
    rel_w[SRC_FULL] = full_n_i;
    set_w[NSRC-1:SRC_AUX0] = aux_evt_i;
    rel_w[NSRC-1:SRC_AUX0] = aux_rel_i;
  end

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_slot
    ic_src_slot u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_w[gi]),
      .ack_i  (ack_i[gi]),
      .rel_i  (rel_w[gi]),
      .pend_o (pend_w[gi]),
      .ackd_o (ackd_w[gi]),
      .clr_o  (clr_w[gi])
    );
  end

  ic_irq_merge #(.NSRC(NSRC)) u_merge (
    .pend_i (pend_w),
    .en_i   (en_q),
    .irq_no (irq_no)
  );

  assign pend_o     = pend_w;
  assign tbl_stat_o = {pend_w[SRC_FULL], full_n_i};
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned NSRC = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            full_n_i,
  input logic            irq_no,
  input logic [NSRC-1:0] ack_i,
  input logic [NSRC-1:0] pend_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] set_w,
  input logic [NSRC-1:0] rel_w,
  input logic [NSRC-1:0] ackd_w
);
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_w[gi] |=> pend_o[gi]); // R10
    AST_HOLD_NO_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[gi] && !rel_w[gi]) |=> pend_o[gi]); // R7
    AST_HOLD_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[gi] && !ackd_w[gi] && !ack_i[gi]) |=> pend_o[gi]); // R8
    AST_IDLE_ACK_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o[gi] && !set_w[gi]) |=> (!pend_o[gi] && !ackd_w[gi])); // R11
  end

  AST_FULL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(full_n_i) && !full_n_i) |=> pend_o[1]); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> irq_no); // R5
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .full_n_i (full_n_i),
  .irq_no   (irq_no),
  .ack_i    (ack_i),
  .pend_o   (pend_o),
  .en_q     (en_q),
  .set_w    (set_w),
  .rel_w    (rel_w),
  .ackd_w   (ackd_w)
);

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  localparam int NAUX = 2;
  localparam int NSRC = 2 + NAUX;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en_we = 1'b0;
  logic [NSRC-1:0] en_wdata = '0;
  logic            lkup = 1'b0;
  logic            rslt_empty = 1'b1;
  logic            full_n = 1'b1;
  logic [NAUX-1:0] aux_evt = '0;
  logic [NAUX-1:0] aux_rel = '0;
  logic [NSRC-1:0] ack = '0;
  logic            irq_n;
  logic [NSRC-1:0] pend;
  logic [1:0]      tstat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl #(.NAUX(NAUX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .lkup_done_i(lkup), .rslt_empty_i(rslt_empty), .full_n_i(full_n),
    .aux_evt_i(aux_evt), .aux_rel_i(aux_rel), .ack_i(ack),
    .irq_no(irq_n), .pend_o(pend), .tbl_stat_o(tstat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, compared every clock
  bit m_pend[NSRC];
  bit m_ackd[NSRC];
  bit m_en[NSRC];
  bit m_prev_full_n = 1;

  always @(posedge clk) begin
    bit ev, rl, cl, hasack;
    int exp_pend;
    bit any_live;
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_ackd[i] = 0; m_en[i] = 0; end
      m_prev_full_n = 1;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (i == 0) begin ev = lkup; rl = rslt_empty; end
        else if (i == 1) begin ev = m_prev_full_n && !full_n; rl = full_n; end
        else begin ev = aux_evt[i-2]; rl = aux_rel[i-2]; end
        hasack = m_ackd[i] || ack[i];
        cl = m_pend[i] && hasack && rl;
        m_ackd[i] = m_pend[i] && !ev && !cl && hasack;
        m_pend[i] = ev || (m_pend[i] && !cl);
      end
      if (en_we) foreach (m_en[i]) m_en[i] = en_wdata[i];
      m_prev_full_n = full_n;
    end
    #3;
    exp_pend = 0;
    any_live = 0;
    for (int i = 0; i < NSRC; i++) begin
      if (m_pend[i]) exp_pend |= (1 << i);
      if (m_pend[i] && m_en[i]) any_live = 1;
    end
    chk("R5 model irq", irq_n, !any_live);
    chk("R2/R3/R12 model pend", pend, exp_pend);
    chk("R4 model tstat", tstat, {m_pend[1], full_n});
  end

  task automatic step();
    @(posedge clk);
    #4;
  endtask

  task automatic wr_en(input logic [NSRC-1:0] v);
    en_we = 1; en_wdata = v; step(); en_we = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    chk("R1 irq", irq_n, 1);
    chk("R1 pend", pend, 0);
    chk("R1 tstat", tstat, 2'b01);
    step();
    chk("R1 enable zero keeps irq high", irq_n, 1);

    wr_en(4'hF);
    lkup = 1; rslt_empty = 0; step(); lkup = 0;
    chk("R2 pend", pend, 4'b0001);
    chk("R5 irq", irq_n, 0);
    ack = 4'b0001; step(); ack = 0;
    chk("R7 ack without release", pend, 4'b0001);
    step();
    chk("R7 still held", pend, 4'b0001);
    rslt_empty = 1; step();
    chk("R7 release after ack", pend, 4'b0000);
    chk("R5 irq idle", irq_n, 1);

    lkup = 1; step(); lkup = 0; step(); step();
    chk("R8 release without ack", pend, 4'b0001);
    ack = 4'b0001; step(); ack = 0;
    chk("R9 ack after release", pend, 4'b0000);

    full_n = 0; step();
    chk("R3 full edge", pend, 4'b0010);
    chk("R4 tstat full", tstat, 2'b10);
    ack = 4'b0010; step(); ack = 0; step();
    chk("R3 held while full", pend, 4'b0010);
    full_n = 1; step();
    chk("R3 release on not full", pend, 4'b0000);
    chk("R4 tstat not full", tstat, 2'b01);

    wr_en(4'h0);
    full_n = 0; step();
    chk("R6 pending while masked", pend, 4'b0010);
    chk("R6 masked irq", irq_n, 1);
    wr_en(4'b0010);
    chk("R6 enable later", irq_n, 0);
    ack = 4'b0010; full_n = 1; step(); ack = 0;
    chk("R6 cleared", pend, 4'b0000);
    wr_en(4'hF);

    aux_evt = 2'b01; step(); aux_evt = 0;
    chk("R12 aux set", pend, 4'b0100);
    ack = 4'b0100; step(); ack = 0;
    chk("R12 ack without release", pend, 4'b0100);
    aux_rel = 2'b01; aux_evt = 2'b01; step(); aux_evt = 0;
    chk("R10 event beats clear", pend, 4'b0100);
    step();
    chk("R10 old ack dropped", pend, 4'b0100);
    ack = 4'b0100; step(); ack = 0;
    chk("R12 fresh ack clears", pend, 4'b0000);
    aux_rel = 0;

    ack = 4'b1000; step(); ack = 0;
    aux_rel = 2'b10; aux_evt = 2'b10; step(); aux_evt = 0; step();
    chk("R11 idle ack ignored", pend, 4'b1000);
    ack = 4'b1000; step(); ack = 0;
    chk("R11 own ack clears", pend, 4'b0000);
    aux_rel = 0;

    for (int c = 0; c < 600; c++) begin
      lkup = ($urandom_range(0, 7) == 0);
      rslt_empty = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 9) == 0) full_n = ~full_n;
      aux_evt = ($urandom_range(0, 5) == 0) ? 2'($urandom) : '0;
      aux_rel = 2'($urandom);
      ack = 4'($urandom) & 4'($urandom);
      en_we = ($urandom_range(0, 19) == 0);
      en_wdata = 4'($urandom);
      step();
    end
    en_we = 0; ack = 0; lkup = 0; aux_evt = 0;
    step();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule